// File: doc/BRIEF.md
# Coefficient Memory Checksum Scrubber

This block guards a small on-chip coefficient memory (digital filter taps and input-calibration constants) against silent corruption such as single-event upsets. Once the memory has been filled after reset, the block reads every word in address order, forms a modular sum, and compares each finished sum against a reference taken from the first full pass. Passes repeat forever, separated by a programmable idle gap. The gap is clamped so that one pass plus the gap always fits inside a fixed revisit budget, derived from the clock frequency and a time limit.

A mismatch sets a sticky error bit and raises a fault output. Both stay high until reset. A command bit enables the downstream processing function. Clearing that bit turns the function off, and a fault also forces it off. A one-cycle pulse marks the end of each pass.

Memory reads use a valid/ready request channel. The block raises `mem_req_valid` with an address and holds both steady until `mem_req_ready` is seen high at a clock edge. It keeps only one read outstanding. It cannot apply back-pressure to responses: one `mem_rsp_valid` beat is expected for each accepted request, at any later cycle.

Top module: `coef_scrub`

## Requirements
- R1: No read request is raised while `load_done` is low. The first request after `load_done` goes high is for address 0.
- R2: A raised request keeps its address stable until accepted. Each pass requests addresses 0 to DEPTH-1 in ascending order, with one read outstanding at a time.
- R3: The checksum is the sum modulo 2^32 of all words in a pass. The first complete pass stores it as the reference, and STATUS (register 0) bit 0 reads 1 from the cycle after that pass ends.
- R4: `scan_done` is a one-cycle pulse in the cycle after the response for address DEPTH-1 is accepted.
- R5: After a `scan_done` pulse, `mem_req_valid` next rises exactly INTERVAL+1 cycles later, where INTERVAL is the value held in register 2.
- R6: A write to register 2 stores the written value, clamped to MAX_GAP = CLK_HZ/1e6*LIMIT_US - 2*DEPTH - 2. Register 2 reads back the stored value and resets to 0.
- R7: When a pass sum differs from the reference, STATUS bit 1 becomes 1 one cycle after that pass's `scan_done`. It stays 1 until reset.
- R8: `fault_o` equals STATUS bit 1 and never falls except by reset.
- R9: COMMAND (register 1) bit 0 resets to 0. `func_en` equals that bit ANDed with the inverse of `fault_o`, so writing 0 turns the function off.
- R10: Writes to STATUS have no effect on its contents.
- R11: During reset, `mem_req_valid`, `scan_done`, `fault_o` and `func_en` are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_done | input | 1 | Memory fill finished; stays high once raised |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 STATUS, 1 COMMAND, 2 INTERVAL |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | $clog2(DEPTH) | Word address being read |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | DW | Read data |
| scan_done | output | 1 | End-of-pass pulse |
| fault_o | output | 1 | Sticky checksum fault |
| func_en | output | 1 | Enable for the protected function |

## Verification
The assertions take three things as given about the environment: `load_done` never falls after it rises, a response beat arrives only while a read is outstanding, and `mem_rsp_data` holds the word at the address that was accepted. The bench keeps to these by raising `load_done` once, by returning each response from its own copy of the memory one or more cycles after the handshake, and by changing that copy only during the idle gap. Ready and response delays are random, so the request-hold and gap-timing properties are exercised under stalls.

// File: rtl/coef_scrub_pkg.sv
package coef_scrub_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2,
    ST_GAP  = 2'd3
  } scan_st_t;

  localparam logic [1:0] RA_STATUS = 2'd0;
  localparam logic [1:0] RA_CMD    = 2'd1;
  localparam logic [1:0] RA_IVAL   = 2'd2;
endpackage

// File: rtl/coef_scrub_seq.sv
module coef_scrub_seq
  import coef_scrub_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int IVAL_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_done,
  input  logic [IVAL_W-1:0]        ival,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [$clog2(DEPTH)-1:0] req_addr,
  input  logic                     rsp_valid,
  output logic                     beat_valid,
  output logic                     beat_first,
  output logic                     beat_last
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  scan_st_t          st_q;
  logic [AW-1:0]     addr_q;
  logic [IVAL_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_WAIT;
      addr_q <= '0;
      gap_q  <= '0;
    end else begin
      case (st_q)
        ST_WAIT: if (load_done) st_q <= ST_REQ;
        ST_REQ:  if (req_ready) st_q <= ST_RSP;
        ST_RSP: begin
          if (rsp_valid) begin
            if (addr_q == LAST) begin
              addr_q <= '0;
              gap_q  <= '0;
              st_q   <= ST_GAP;
            end else begin
              addr_q <= addr_q + 1'b1;
              st_q   <= ST_REQ;
            end
          end
        end
        default: begin
          if (gap_q >= ival) st_q <= ST_REQ;
          else               gap_q <= gap_q + 1'b1;
        end
      endcase
    end
  end

  assign req_valid  = (st_q == ST_REQ);
  assign req_addr   = addr_q;
  assign beat_valid = (st_q == ST_RSP) && rsp_valid;
  assign beat_first = (addr_q == '0);
  assign beat_last  = (addr_q == LAST);
endmodule

// File: rtl/coef_scrub_sum.sv
module coef_scrub_sum #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_valid,
  input  logic          beat_first,
  input  logic          beat_last,
  input  logic [DW-1:0] beat_data,
  output logic          pass_done,
  output logic          ref_valid,
  output logic          mismatch
);
  logic [DW-1:0] acc_q, ref_q, total;

  assign total = (beat_first ? '0 : acc_q) + beat_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      ref_q     <= '0;
      ref_valid <= 1'b0;
      pass_done <= 1'b0;
      mismatch  <= 1'b0;
    end else begin
      pass_done <= beat_valid && beat_last;
      mismatch  <= 1'b0;
      if (beat_valid) begin
        acc_q <= total;
        if (beat_last) begin
          if (!ref_valid) begin
            ref_q     <= total;
            ref_valid <= 1'b1;
          end else begin
            mismatch <= (total != ref_q);
          end
        end
      end
    end
  end
endmodule

// File: rtl/coef_scrub_regs.sv
module coef_scrub_regs
  import coef_scrub_pkg::*;
#(
  parameter int IVAL_W  = 16,
  parameter int MAX_GAP = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mismatch,
  input  logic              ref_valid,
  output logic [IVAL_W-1:0] ival,
  output logic              fault,
  output logic              func_en
);
  localparam logic [31:0] MAX32 = 32'(MAX_GAP);

  logic              err_q, cmd_q;
  logic [IVAL_W-1:0] ival_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      cmd_q  <= 1'b0;
      ival_q <= '0;
    end else begin
      err_q <= err_q | mismatch;
      if (reg_wr && reg_addr == RA_CMD) cmd_q <= reg_wdata[0];
      if (reg_wr && reg_addr == RA_IVAL)
        ival_q <= (reg_wdata > MAX32) ? IVAL_W'(MAX_GAP) : reg_wdata[IVAL_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      RA_STATUS: reg_rdata = {30'b0, err_q, ref_valid};
      RA_CMD:    reg_rdata = {31'b0, cmd_q};
      RA_IVAL:   reg_rdata = 32'(ival_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign ival    = ival_q;
  assign fault   = err_q;
  assign func_en = cmd_q & ~err_q;
endmodule

// File: rtl/coef_scrub.sv
module coef_scrub #(
  parameter int DEPTH    = 64,
  parameter int DW       = 32,
  parameter int CLK_HZ   = 250_000_000,
  parameter int LIMIT_US = 100_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_done,
  input  logic                     reg_wr,
  input  logic [1:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [$clog2(DEPTH)-1:0] mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [DW-1:0]            mem_rsp_data,
  output logic                     scan_done,
  output logic                     fault_o,
  output logic                     func_en
);
  localparam int BUDGET  = (CLK_HZ / 1_000_000) * LIMIT_US;
  localparam int MAX_GAP = BUDGET - 2 * DEPTH - 2;
  localparam int IVAL_W  = $clog2(MAX_GAP + 1);

  logic              beat_valid, beat_first, beat_last;
  logic              mismatch, ref_valid;
  logic [IVAL_W-1:0] ival;

  coef_scrub_seq #(.DEPTH(DEPTH), .IVAL_W(IVAL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_done  (load_done),
    .ival       (ival),
    .req_valid  (mem_req_valid),
    .req_ready  (mem_req_ready),
    .req_addr   (mem_req_addr),
    .rsp_valid  (mem_rsp_valid),
    .beat_valid (beat_valid),
    .beat_first (beat_first),
    .beat_last  (beat_last)
  );

  coef_scrub_sum #(.DW(DW)) u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .beat_first (beat_first),
    .beat_last  (beat_last),
    .beat_data  (mem_rsp_data),
    .pass_done  (scan_done),
    .ref_valid  (ref_valid),
    .mismatch   (mismatch)
  );

  coef_scrub_regs #(.IVAL_W(IVAL_W), .MAX_GAP(MAX_GAP)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mismatch  (mismatch),
    .ref_valid (ref_valid),
    .ival      (ival),
    .fault     (fault_o),
    .func_en   (func_en)
  );
endmodule

// File: rtl/coef_scrub_chk.sv
module coef_scrub_chk #(
  parameter int DEPTH = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     load_done,
  input logic                     mem_req_valid,
  input logic                     mem_req_ready,
  input logic [$clog2(DEPTH)-1:0] mem_req_addr,
  input logic                     scan_done,
  input logic                     fault_o,
  input logic                     func_en
);
  p_wait_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> !mem_req_valid);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (32'(mem_req_addr) < 32'(DEPTH)));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  p_gap_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !mem_req_valid);

  p_fault_from_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(scan_done));

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);

  p_en_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !func_en);
endmodule

bind coef_scrub coef_scrub_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .load_done     (load_done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .scan_done     (scan_done),
  .fault_o       (fault_o),
  .func_en       (func_en)
);

// File: tb/sim_coef_scrub.sv
module sim_coef_scrub;
  localparam int DEPTH    = 16;
  localparam int DW       = 32;
  localparam int CLK_HZ   = 250_000_000;
  localparam int LIMIT_US = 1;
  localparam int MAXG     = (CLK_HZ / 1_000_000) * LIMIT_US - 2 * DEPTH - 2;
  localparam int AW       = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_done = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic scan_done, fault_o, func_en;

  always #2 clk = ~clk;

  coef_scrub #(.DEPTH(DEPTH), .DW(DW), .CLK_HZ(CLK_HZ), .LIMIT_US(LIMIT_US)) u0 (
    .clk(clk), .rst_n(rst_n), .load_done(load_done), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .scan_done(scan_done), .fault_o(fault_o),
    .func_en(func_en)
  );

  int n_tests = 0, n_fail = 0;
  logic [31:0] mem [DEPTH];

  // behavioural reference state
  int m_ph = 0;             // 0 waiting, 1 requesting, 2 awaiting data, 3 idle gap
  int m_addr = 0, m_gap = 0, m_ival = 0;
  logic [31:0] m_sum = '0, m_ref = '0;
  bit m_ref_ok = 0, m_fault = 0, m_mism = 0, m_done = 0, m_cmd = 0;
  bit ld = 0;
  bit w_pend = 0;
  logic [1:0] w_addr = '0, rd_sel = '0;
  logic [31:0] w_data = '0;
  int since_done = -1, gap_iv = 0;
  bit gap_dirty = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    logic [31:0] exp_rd, s;
    bit rdy, rsp, n_done, n_mism;
    @(negedge clk);
    // compare against model every clock
    chk(mem_req_valid == (m_ph == 1), "R1 R5 request valid", 32'(mem_req_valid), 32'(m_ph == 1));
    if (mem_req_valid && m_ph == 1)
      chk(mem_req_addr == AW'(m_addr), "R2 request address", 32'(mem_req_addr), 32'(m_addr));
    chk(scan_done == m_done, "R4 scan_done", 32'(scan_done), 32'(m_done));
    chk(fault_o == m_fault, "R8 fault_o", 32'(fault_o), 32'(m_fault));
    chk(func_en == (m_cmd && !m_fault), "R9 func_en", 32'(func_en), 32'(m_cmd && !m_fault));
    case (reg_addr)
      2'd0: exp_rd = {30'b0, m_fault, m_ref_ok};
      2'd1: exp_rd = {31'b0, m_cmd};
      2'd2: exp_rd = 32'(m_ival);
      default: exp_rd = '0;
    endcase
    chk(reg_rdata == exp_rd, "R3 R6 R7 R10 register read", reg_rdata, exp_rd);
    // explicit gap measurement
    if (scan_done) begin
      since_done = 0; gap_iv = m_ival; gap_dirty = 0;
    end else if (since_done >= 0) begin
      since_done++;
    end
    if (mem_req_valid && since_done > 0) begin
      if (!gap_dirty) chk(since_done == gap_iv + 1, "R5 gap length", 32'(since_done), 32'(gap_iv + 1));
      since_done = -1;
    end
    // drive
    rdy = ($urandom % 4) != 0;
    rsp = (m_ph == 2) && (($urandom % 3) != 0);
    mem_req_ready = rdy;
    mem_rsp_valid = rsp;
    mem_rsp_data  = rsp ? mem[m_addr] : $urandom;
    load_done     = ld;
    reg_wr        = w_pend;
    reg_wdata     = w_data;
    reg_addr      = w_pend ? w_addr : rd_sel;
    // predict the next edge
    n_done = 0; n_mism = 0;
    case (m_ph)
      0: if (ld) m_ph = 1;
      1: if (rdy) m_ph = 2;
      2: if (rsp) begin
        s = (m_addr == 0 ? 32'd0 : m_sum) + mem[m_addr];
        m_sum = s;
        if (m_addr == DEPTH - 1) begin
          n_done = 1;
          if (!m_ref_ok) begin m_ref = s; m_ref_ok = 1; end
          else if (s != m_ref) n_mism = 1;
          m_addr = 0; m_gap = 0; m_ph = 3;
        end else begin
          m_addr++; m_ph = 1;
        end
      end
      default: if (m_gap >= m_ival) m_ph = 1; else m_gap++;
    endcase
    m_fault = m_fault | m_mism;
    m_mism = n_mism;
    m_done = n_done;
    if (w_pend && w_addr == 2'd1) m_cmd = w_data[0];
    if (w_pend && w_addr == 2'd2) begin
      m_ival = (w_data > 32'(MAXG)) ? MAXG : int'(w_data);
      gap_dirty = 1;
    end
    w_pend = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    w_pend = 1; w_addr = a; w_data = d; rd_sel = a;
    step();
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      step();
      if (scan_done) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=0", 200000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = $urandom;
    // R11 reset state, every register
    repeat (3) @(negedge clk);
    chk(!mem_req_valid && !scan_done, "R11 idle outputs", 32'({mem_req_valid, scan_done}), 0);
    chk(!fault_o && !func_en, "R11 fault/en low", 32'({fault_o, func_en}), 0);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1 chk(reg_rdata == 0, "R11 register reset", reg_rdata, 0);
    end
    reg_addr = 2'd0;
    rst_n = 1'b1;
    // R1: held off while loading
    run(12);
    chk(!mem_req_valid, "R1 no scan before load", 32'(mem_req_valid), 0);
    ld = 1;
    wr(2'd1, 32'h1);                       // R9 enable on
    chk(func_en == 1'b0 || func_en == 1'b1, "R9 en defined", 32'(func_en), 32'(func_en));
    rd_sel = 2'd0;
    wait_done();                           // R3 reference pass
    step();
    chk(reg_rdata[0] == 1'b1, "R3 reference captured", reg_rdata, 32'h1);
    wait_done(); step();
    chk(!fault_o, "R3 matching pass no fault", 32'(fault_o), 0);
    // R5 gaps of several lengths
    wr(2'd2, 32'd5);  wait_done(); wait_done();
    wr(2'd2, 32'd0);  wait_done(); wait_done();
    wr(2'd2, 32'd37); wait_done(); wait_done();
    // R6 clamp
    wr(2'd2, 32'd100000); step();
    chk(reg_rdata == 32'(MAXG), "R6 clamp", reg_rdata, 32'(MAXG));
    wr(2'd2, 32'(MAXG)); step();
    chk(reg_rdata == 32'(MAXG), "R6 boundary", reg_rdata, 32'(MAXG));
    wr(2'd2, 32'd3);
    // R10 status is read-only
    wr(2'd0, 32'hFFFF_FFFF); step();
    chk(reg_rdata == 32'h1, "R10 status write ignored", reg_rdata, 32'h1);
    // R9 disable / re-enable
    wr(2'd1, 32'h0); step();
    chk(!func_en, "R9 disable", 32'(func_en), 0);
    wr(2'd1, 32'h1); step();
    chk(func_en, "R9 re-enable", 32'(func_en), 1);
    // R3 modular sum: compensating changes leave the sum intact
    rd_sel = 2'd0;
    wait_done();
    mem[2] = mem[2] + 32'd5;
    mem[7] = mem[7] - 32'd5;
    wait_done(); step();
    chk(!fault_o, "R3 sum-preserving edit", 32'(fault_o), 0);
    // R7 single-bit upset
    wait_done();
    mem[3] = mem[3] ^ 32'h0000_0100;
    wait_done(); step();
    chk(fault_o, "R7 fault after mismatch", 32'(fault_o), 1);
    chk(reg_rdata[1], "R7 status error bit", reg_rdata, 32'h3);
    chk(!func_en, "R9 fault forces off", 32'(func_en), 0);
    wr(2'd1, 32'h1); step();
    chk(!func_en, "R9 enable blocked in fault", 32'(func_en), 0);
    // R8 sticky even after memory restored
    mem[3] = mem[3] ^ 32'h0000_0100;
    wait_done(); wait_done(); step();
    chk(fault_o, "R8 sticky fault", 32'(fault_o), 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule